// File: doc/BRIEF.md
# Multichannel DMA Controller with Request/Acknowledge Handshake

The block moves data between locations on one shared system bus on behalf of several independent channels. Each channel holds a source address, a destination address and a unit count. Software sets them up through a small register write port. A channel then runs in one of two ways. In peripheral mode it waits for its request line. In memory-to-memory mode it starts as soon as it is enabled. Each unit is one read from the source followed by one write to the destination, carried out on a simple single-cycle memory master port.

Before touching memory the controller asks the CPU side for the bus with a request/grant pair. In cycle-stealing mode it gives the bus back after every unit. In burst mode it keeps the bus until the channel's block is finished. Peripheral transfers are closed with a four-phase request/acknowledge exchange. When a channel's count passes zero and wraps to all ones, it pulses its terminal-count line, latches a done flag that can drive the interrupt, and then either stops or reloads its start values.

Top module: `dmac_top`

## Requirements
- R1: When several channels are ready in the same cycle that the controller is idle, the lowest-numbered channel is served first.
- R2: For a peripheral-mode channel, `dack` rises for that channel only in the cycle after the unit's memory write. It stays high while that channel's `dreq` is high and falls only after `dreq` has been seen low. At most one `dack` bit is high at a time.
- R3: A channel with control bit 1 (memory-to-memory) set starts transferring once control bit 0 (enable) is written to 1, with every `dreq` low.
- R4: With control bit 2 (burst) clear, `bus_req` falls after every unit. It is not raised again until `bus_grant` has been seen low.
- R5: With control bit 2 set, `bus_req` stays high from the first unit of a block to its last unit, so it falls once per block.
- R6: A count value N written to register 2 gives N+1 units. On the last unit (count 0 wrapping to 16'hFFFF) the channel's `tc` bit pulses for one cycle. Without auto-initialize the channel then clears its enable and makes no further accesses.
- R7: Control bits [7:6] give the source unit size and bits [9:8] the destination unit size (0 = 8 bit, 1 = 16 bit, 2 or 3 = 32 bit). The value read is zero-extended or truncated to the destination size. The source address advances by its unit size only if control bit 4 is set, and the destination address only if control bit 5 is set. Each read is followed by its write in the next cycle.
- R8: With control bit 3 (auto-initialize) set, terminal count reloads the working addresses and count from the values last written to registers 0, 1 and 2. The channel stays enabled.
- R9: `irq` is high while any channel has both its done flag and control bit 10 (interrupt enable) set. Writing a value with bit 0 set to register 4 clears that channel's done flag.
- R10: `mem_req` is high only while both `bus_req` and `bus_grant` are high.
- R11: While `rst` is high, `bus_req`, `mem_req`, `dack`, `tc` and `irq` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | CHW | Channel selected by the write |
| cfg_reg | input | 3 | Register index: 0 source, 1 destination, 2 count, 3 control, 4 clear done |
| cfg_data | input | RW | Write data |
| dreq | input | NCH | Per-channel peripheral request |
| dack | output | NCH | Per-channel acknowledge |
| bus_req | output | 1 | Bus request to the CPU side |
| bus_grant | input | 1 | Bus grant from the CPU side |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address |
| mem_size | output | 2 | Unit size code (0 byte, 1 half, 2 word) |
| mem_wdata | output | 32 | Write data, low-aligned |
| mem_rdata | input | 32 | Read data, valid in the access cycle |
| tc | output | NCH | One-cycle terminal-count pulse per channel |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the controller with four channels and 16-bit addresses and counts. This places two peripheral channels in contention for the priority order. Separate channels then cover memory-to-memory burst, memory-to-memory cycle stealing, auto-initialize and peripheral burst. The 16-bit count lets short blocks reach the wrap from 0 to all ones within a few units. Mixed size codes bring the zero-extend, truncate and fixed-address paths into play.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    localparam int DATA_W = 32;

    // register indices on the configuration port
    localparam logic [2:0] REG_SRC  = 3'd0;
    localparam logic [2:0] REG_DST  = 3'd1;
    localparam logic [2:0] REG_CNT  = 3'd2;
    localparam logic [2:0] REG_CTRL = 3'd3;
    localparam logic [2:0] REG_CLR  = 3'd4;

    typedef enum logic [2:0] {
        S_IDLE, S_BREQ, S_RD, S_WR, S_ACK, S_HOLD, S_REL
    } dma_state_e;

    // control word, bit 0 is enable, bit 10 is interrupt enable
    typedef struct packed {
        logic       irq_en;
        logic [1:0] dsz;
        logic [1:0] ssz;
        logic       dinc;
        logic       sinc;
        logic       autoinit;
        logic       burst;
        logic       m2m;
        logic       en;
    } chan_ctrl_t;

    // the part of the control word the sequencer needs
    typedef struct packed {
        logic       en;
        logic       m2m;
        logic       burst;
        logic       irq_en;
        logic [1:0] ssz;
        logic [1:0] dsz;
    } chan_view_t;

    function automatic logic [2:0] unit_bytes(input logic [1:0] sz);
        case (sz)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] unit_mask(input logic [DATA_W-1:0] d,
                                                    input logic [1:0] sz);
        case (sz)
            2'd0:    return {{(DATA_W-8){1'b0}}, d[7:0]};
            2'd1:    return {{(DATA_W-16){1'b0}}, d[15:0]};
            default: return d;
        endcase
    endfunction

endpackage

// File: rtl/dmac_prio.sv
module dmac_prio #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    // lowest index wins (R1)
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/dmac_chan.sv
module dmac_chan
    import dmac_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int RW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_reg,
    input  logic [RW-1:0] cfg_data,
    input  logic          step,
    output logic [AW-1:0] src_o,
    output logic [AW-1:0] dst_o,
    output chan_view_t    view_o,
    output logic          last_o,
    output logic          done_o,
    output logic          tc_o
);
    localparam int CTRL_W = $bits(chan_ctrl_t);

    logic [AW-1:0] src_base, dst_base, src_cur, dst_cur;
    logic [CW-1:0] cnt_base, cnt_cur;
    chan_ctrl_t    ctrl;
    logic          done_q, tc_q;
    logic          wrap;

    assign wrap = (cnt_cur == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            src_base <= '0;
            dst_base <= '0;
            cnt_base <= '0;
            src_cur  <= '0;
            dst_cur  <= '0;
            cnt_cur  <= '0;
            ctrl     <= '0;
            done_q   <= 1'b0;
            tc_q     <= 1'b0;
        end else begin
            tc_q <= 1'b0;
            if (step) begin
                if (ctrl.sinc) src_cur <= src_cur + AW'(unit_bytes(ctrl.ssz));  // R7
                if (ctrl.dinc) dst_cur <= dst_cur + AW'(unit_bytes(ctrl.dsz));
                cnt_cur <= cnt_cur - 1'b1;
                if (wrap) begin                                                // R6
                    tc_q   <= 1'b1;
                    done_q <= 1'b1;
                    if (ctrl.autoinit) begin                                   // R8
                        src_cur <= src_base;
                        dst_cur <= dst_base;
                        cnt_cur <= cnt_base;
                    end else begin
                        ctrl.en <= 1'b0;
                    end
                end
            end
            if (cfg_we) begin
                case (cfg_reg)
                    REG_SRC: begin
                        src_base <= cfg_data[AW-1:0];
                        src_cur  <= cfg_data[AW-1:0];
                    end
                    REG_DST: begin
                        dst_base <= cfg_data[AW-1:0];
                        dst_cur  <= cfg_data[AW-1:0];
                    end
                    REG_CNT: begin
                        cnt_base <= cfg_data[CW-1:0];
                        cnt_cur  <= cfg_data[CW-1:0];
                    end
                    REG_CTRL: ctrl <= chan_ctrl_t'(cfg_data[CTRL_W-1:0]);
                    REG_CLR:  if (cfg_data[0]) done_q <= 1'b0;                 // R9
                    default: ;
                endcase
            end
        end
    end

    assign src_o  = src_cur;
    assign dst_o  = dst_cur;
    assign last_o = wrap;
    assign done_o = done_q;
    assign tc_o   = tc_q;
    assign view_o = '{en: ctrl.en, m2m: ctrl.m2m, burst: ctrl.burst,
                      irq_en: ctrl.irq_en, ssz: ctrl.ssz, dsz: ctrl.dsz};
endmodule

// File: rtl/dmac_top.sv
module dmac_top
    import dmac_pkg::*;
#(
    parameter int  NCH = 4,
    parameter int  AW  = 16,
    parameter int  CW  = 16,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int RW  = (AW > CW) ? AW : CW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CHW-1:0]    cfg_ch,
    input  logic [2:0]        cfg_reg,
    input  logic [RW-1:0]     cfg_data,
    input  logic [NCH-1:0]    dreq,
    output logic [NCH-1:0]    dack,
    output logic              bus_req,
    input  logic              bus_grant,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [1:0]        mem_size,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [NCH-1:0]    tc,
    output logic              irq
);
    logic [AW-1:0] src_a [NCH];
    logic [AW-1:0] dst_a [NCH];
    chan_view_t    view  [NCH];
    logic [NCH-1:0] last_v, done_v, ie_v, pend, step;

    dma_state_e        state;
    logic [CHW-1:0]    cur, pick;
    logic              any;
    logic [DATA_W-1:0] data_q;
    logic              last_q;
    chan_view_t        cv;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        dmac_chan #(.AW(AW), .CW(CW), .RW(RW)) u_chan (
            .clk      (clk),
            .rst      (rst),
            .cfg_we   (cfg_we && (cfg_ch == CHW'(g))),
            .cfg_reg  (cfg_reg),
            .cfg_data (cfg_data),
            .step     (step[g]),
            .src_o    (src_a[g]),
            .dst_o    (dst_a[g]),
            .view_o   (view[g]),
            .last_o   (last_v[g]),
            .done_o   (done_v[g]),
            .tc_o     (tc[g])
        );
        // memory-to-memory channels need no request (R3)
        assign pend[g] = view[g].en && (view[g].m2m || dreq[g]);
        assign ie_v[g] = view[g].irq_en;
    end

    dmac_prio #(.N(NCH), .IW(CHW)) u_prio (
        .req (pend),
        .any (any),
        .idx (pick)
    );

    assign cv = view[cur];

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            cur    <= '0;
            data_q <= '0;
            last_q <= 1'b0;
        end else begin
            case (state)
                S_IDLE: if (any) begin
                    cur   <= pick;
                    state <= S_BREQ;
                end
                S_BREQ: if (bus_grant) state <= S_RD;                          // R10
                S_RD: begin
                    data_q <= unit_mask(mem_rdata, cv.ssz);
                    state  <= S_WR;
                end
                S_WR: begin
                    last_q <= last_v[cur];
                    if (cv.m2m)
                        state <= (cv.burst && !last_v[cur]) ? S_RD : S_REL;  // R4 R5
                    else
                        state <= S_ACK;
                end
                S_ACK: if (!dreq[cur])                                         // R2
                    state <= (cv.burst && !last_q) ? S_HOLD : S_REL;
                S_HOLD: begin
                    if (!cv.en)          state <= S_REL;
                    else if (dreq[cur])  state <= S_RD;
                end
                S_REL: if (!bus_grant) state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        bus_req   = (state == S_BREQ) || (state == S_RD) || (state == S_WR) ||
                    (state == S_ACK)  || (state == S_HOLD);
        mem_req   = (state == S_RD) || (state == S_WR);
        mem_we    = (state == S_WR);
        mem_addr  = (state == S_WR) ? dst_a[cur] : src_a[cur];
        mem_size  = (state == S_WR) ? cv.dsz : cv.ssz;
        mem_wdata = unit_mask(data_q, cv.dsz);
        dack      = (state == S_ACK) ? (NCH'(1) << cur) : '0;
        step      = (state == S_WR)  ? (NCH'(1) << cur) : '0;
        irq       = |(done_v & ie_v);                                          // R9
    end
endmodule

// File: rtl/dmac_top_chk.sv
module dmac_top_chk #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst,
    input logic           bus_req,
    input logic           bus_grant,
    input logic           mem_req,
    input logic           mem_we,
    input logic [NCH-1:0] dack,
    input logic [NCH-1:0] dreq,
    input logic [NCH-1:0] tc
);
    AST_MEM_NEEDS_GRANT: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (bus_req && bus_grant));                                   // R10
    AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dack));                                                       // R2
    AST_ACK_HOLD: assert property (@(posedge clk) disable iff (rst)
        ((dack & dreq) != '0) |=> ((dack & $past(dack)) != '0));               // R2
    AST_ACK_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        $rose(|dack) |-> $past(mem_req && mem_we));                            // R2
    AST_ACK_DROP: assert property (@(posedge clk) disable iff (rst)
        $fell(|dack) |-> $past((dack & dreq) == '0));                          // R2
    AST_RD_THEN_WR: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |=> (mem_req && mem_we));                         // R7
    AST_TC_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(tc));                                                         // R6
endmodule

bind dmac_top dmac_top_chk #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_req   (bus_req),
    .bus_grant (bus_grant),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .dack      (dack),
    .dreq      (dreq),
    .tc        (tc)
);

// File: tb/tb_dmac_top.sv
`timescale 1ns/1ps
module tb_dmac_top;
    import dmac_pkg::*;

    localparam int NCH = 4;
    localparam int AW  = 16;
    localparam int CW  = 16;
    localparam int CHW = 2;
    localparam int RW  = 16;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic           rst;
    logic           cfg_we;
    logic [CHW-1:0] cfg_ch;
    logic [2:0]     cfg_reg;
    logic [RW-1:0]  cfg_data;
    logic [NCH-1:0] dreq;
    logic [NCH-1:0] dack;
    logic           bus_req, bus_grant;
    logic           mem_req, mem_we;
    logic [AW-1:0]  mem_addr;
    logic [1:0]     mem_size;
    logic [31:0]    mem_wdata, mem_rdata;
    logic [NCH-1:0] tc;
    logic           irq;

    dmac_top #(.NCH(NCH), .AW(AW), .CW(CW)) dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_reg(cfg_reg),
        .cfg_data(cfg_data), .dreq(dreq), .dack(dack), .bus_req(bus_req),
        .bus_grant(bus_grant), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .tc(tc), .irq(irq)
    );

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    // ---------------- memory and CPU-side arbiter models ----------------
    logic [7:0] mem [0:4095];
    initial for (int i = 0; i < 4096; i++) mem[i] = 8'((i * 7 + 3) & 255);

    always_comb begin
        mem_rdata = {mem[(int'(mem_addr[11:0]) + 3) & 4095], mem[(int'(mem_addr[11:0]) + 2) & 4095],
                     mem[(int'(mem_addr[11:0]) + 1) & 4095], mem[int'(mem_addr[11:0])]};
    end

    function automatic int nbytes(input int sz);
        return (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    endfunction

    always @(posedge clk) begin
        if (!rst && mem_req && mem_we)
            for (int i = 0; i < nbytes(int'(mem_size)); i++)
                mem[(int'(mem_addr[11:0]) + i) & 4095] <= mem_wdata[8*i +: 8];
    end

    always @(posedge clk) bus_grant <= rst ? 1'b0 : bus_req;

    // ---------------- peripheral models: four-phase handshake ----------------
    int quota [NCH];
    int used  [NCH];
    initial for (int c = 0; c < NCH; c++) quota[c] = 0;
    always @(negedge clk) begin
        for (int c = 0; c < NCH; c++) begin
            if (rst) begin
                dreq[c] <= 1'b0;
                used[c] = 0;
            end else if (dreq[c] && dack[c]) begin
                dreq[c] <= 1'b0;
            end else if (!dreq[c] && !dack[c] && used[c] < quota[c]) begin
                dreq[c] <= 1'b1;
                used[c] = used[c] + 1;
            end
        end
    end

    // ---------------- reference model: expected write stream ----------------
    int          q_addr [$];
    int          q_size [$];
    logic [31:0] q_data [$];
    string       cur_req = "R7";

    function automatic logic [31:0] rdv(input int a, input int sz);
        logic [31:0] v = '0;
        for (int i = 0; i < nbytes(sz); i++) v[8*i +: 8] = mem[(a + i) & 4095];
        return v;
    endfunction

    task automatic plan(input int s, input int d, input int ssz, input int dsz,
                        input bit sinc, input bit dinc, input int units);
        logic [31:0] m;
        for (int u = 0; u < units; u++) begin
            m = (dsz == 0) ? 32'hFF : (dsz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
            q_addr.push_back(d);
            q_size.push_back(dsz);
            q_data.push_back(rdv(s, ssz) & m);
            if (sinc) s += nbytes(ssz);
            if (dinc) d += nbytes(dsz);
        end
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- per-cycle monitor ----------------
    int nwr, breq_falls, ack_rises, nogrant;
    int tc_cnt [NCH];
    logic prev_breq = 1'b0;
    logic prev_ack  = 1'b0;

    task automatic clr_cnt();
        nwr = 0; breq_falls = 0; ack_rises = 0;
        for (int c = 0; c < NCH; c++) tc_cnt[c] = 0;
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (mem_req && !(bus_req && bus_grant)) nogrant++;
            if (mem_req && mem_we) begin
                nwr++;
                if (q_addr.size() == 0) begin
                    chk("R6 unexpected write", {16'h0, mem_addr}, 32'hFFFF_FFFF);
                end else begin
                    chk({cur_req, " write address"}, {16'h0, mem_addr}, 32'(q_addr.pop_front()));
                    chk({cur_req, " write size"}, {30'h0, mem_size}, 32'(q_size.pop_front()));
                    chk({cur_req, " write data"}, mem_wdata, q_data.pop_front());
                end
            end
            for (int c = 0; c < NCH; c++) if (tc[c]) tc_cnt[c]++;
            if (prev_breq && !bus_req) breq_falls++;
            if (!prev_ack && (|dack)) ack_rises++;
            prev_breq = bus_req;
            prev_ack  = |dack;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic cfgw(input int ch, input logic [2:0] r, input int d);
        cfg_ch   = CHW'(ch);
        cfg_reg  = r;
        cfg_data = RW'(d);
        cfg_we   = 1'b1;
        @(negedge clk);
        cfg_we   = 1'b0;
    endtask

    function automatic int ctl(input bit en, input bit m2m, input bit burst, input bit ai,
                               input bit sinc, input bit dinc, input int ssz,
                               input int dsz, input bit ie);
        return (int'(ie) << 10) | (dsz << 8) | (ssz << 6) | (int'(dinc) << 5) |
               (int'(sinc) << 4) | (int'(ai) << 3) | (int'(burst) << 2) |
               (int'(m2m) << 1) | int'(en);
    endfunction

    task automatic wait_idle();
        int n = 0;
        while ((q_addr.size() != 0 || bus_req || bus_grant) && n < 5000) begin
            @(negedge clk);
            n++;
        end
        if (n >= 5000) chk("R6 completion timeout", 32'(q_addr.size()), 32'd0);
        repeat (10) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++;
            total++;
            $display("FAIL R6 watchdog actual=%0d expected=completion", cyc);
            finish_run();
        end
    end

    // ---------------- tests ----------------
    initial begin
        nogrant = 0;
        clr_cnt();
        rst = 1'b1; cfg_we = 1'b0; cfg_ch = '0; cfg_reg = '0; cfg_data = '0;
        repeat (4) @(negedge clk);
        // R11: reset state
        chk("R11 bus_req in reset", {31'h0, bus_req}, 32'd0);
        chk("R11 mem_req in reset", {31'h0, mem_req}, 32'd0);
        chk("R11 dack/tc in reset", {24'h0, dack, tc}, 32'd0);
        chk("R11 irq in reset", {31'h0, irq}, 32'd0);
        rst = 1'b0;
        @(negedge clk);

        // T1: ch2 memory-to-memory burst, word to word, count 3 -> 4 units
        cur_req = "R3";
        clr_cnt();
        cfgw(2, REG_SRC, 'h100);
        cfgw(2, REG_DST, 'h200);
        cfgw(2, REG_CNT, 3);
        plan('h100, 'h200, 2, 2, 1, 1, 4);
        cfgw(2, REG_CTRL, ctl(1, 1, 1, 0, 1, 1, 2, 2, 1));
        wait_idle();
        chk("R3 units moved without request", 32'(nwr), 32'd4);
        chk("R5 bus_req falls once per burst", 32'(breq_falls), 32'd1);
        chk("R6 one tc pulse on ch2", 32'(tc_cnt[2]), 32'd1);
        chk("R9 irq set by done with enable", {31'h0, irq}, 32'd1);
        repeat (20) @(negedge clk);
        chk("R6 no access after terminal count", 32'(nwr), 32'd4);
        cfgw(2, REG_CLR, 1);
        chk("R9 irq cleared by write-one", {31'h0, irq}, 32'd0);

        // T2: ch3 memory-to-memory cycle stealing, byte to half, count 2 -> 3 units
        cur_req = "R7";
        clr_cnt();
        cfgw(3, REG_SRC, 'h300);
        cfgw(3, REG_DST, 'h400);
        cfgw(3, REG_CNT, 2);
        plan('h300, 'h400, 0, 1, 1, 1, 3);
        cfgw(3, REG_CTRL, ctl(1, 1, 0, 0, 1, 1, 0, 1, 0));
        wait_idle();
        chk("R7 byte units widened", 32'(nwr), 32'd3);
        chk("R4 bus_req falls after every unit", 32'(breq_falls), 32'd3);
        chk("R6 one tc pulse on ch3", 32'(tc_cnt[3]), 32'd1);
        chk("R9 irq stays low with enable clear", {31'h0, irq}, 32'd0);

        // T3: ch0 and ch1 peripheral, cycle stealing, fixed source, both requesting
        cur_req = "R1";
        clr_cnt();
        cfgw(0, REG_SRC, 'h500); cfgw(0, REG_DST, 'h600); cfgw(0, REG_CNT, 1);
        cfgw(1, REG_SRC, 'h540); cfgw(1, REG_DST, 'h680); cfgw(1, REG_CNT, 1);
        plan('h500, 'h600, 2, 2, 0, 1, 2);
        plan('h540, 'h680, 2, 2, 0, 1, 2);
        cfgw(0, REG_CTRL, ctl(1, 0, 0, 0, 0, 1, 2, 2, 0));
        cfgw(1, REG_CTRL, ctl(1, 0, 0, 0, 0, 1, 2, 2, 0));
        quota[0] += 2;
        quota[1] += 2;
        wait_idle();
        chk("R1 all units in priority order", 32'(nwr), 32'd4);
        chk("R2 one acknowledge per unit", 32'(ack_rises), 32'd4);
        chk("R4 bus released per peripheral unit", 32'(breq_falls), 32'd4);
        chk("R6 tc on ch0 and ch1", 32'(tc_cnt[0] + tc_cnt[1]), 32'd2);

        // T4: ch1 auto-initialize, half to word, count 1, four requests
        cur_req = "R8";
        clr_cnt();
        cfgw(1, REG_SRC, 'h700); cfgw(1, REG_DST, 'h800); cfgw(1, REG_CNT, 1);
        plan('h700, 'h800, 1, 2, 1, 1, 2);
        plan('h700, 'h800, 1, 2, 1, 1, 2);
        cfgw(1, REG_CTRL, ctl(1, 0, 0, 1, 1, 1, 1, 2, 0));
        quota[1] += 4;
        wait_idle();
        chk("R8 reloaded block repeats", 32'(nwr), 32'd4);
        chk("R8 two tc pulses", 32'(tc_cnt[1]), 32'd2);
        clr_cnt();
        plan('h700, 'h800, 1, 2, 1, 1, 2);
        quota[1] += 2;
        wait_idle();
        chk("R8 channel still enabled after reload", 32'(nwr), 32'd2);

        // T5: ch0 peripheral burst, word to byte, count 2 -> 3 units
        cur_req = "R5";
        clr_cnt();
        cfgw(0, REG_SRC, 'h900); cfgw(0, REG_DST, 'hA00); cfgw(0, REG_CNT, 2);
        plan('h900, 'hA00, 2, 0, 1, 1, 3);
        cfgw(0, REG_CTRL, ctl(1, 0, 1, 0, 1, 1, 2, 0, 0));
        quota[0] += 3;
        wait_idle();
        chk("R7 word truncated to byte units", 32'(nwr), 32'd3);
        chk("R5 bus held across peripheral burst", 32'(breq_falls), 32'd1);
        chk("R2 acknowledge per burst unit", 32'(ack_rises), 32'd3);

        chk("R10 no access without grant", 32'(nogrant), 32'd0);
        finish_run();
    end
endmodule